// File: doc/BRIEF.md
# Boundary Scan Pin Cell Chain

This block is the data-register side of boundary scan for a row of bidirectional pins. Every pin gets three cells: one for the value arriving at the pad, one for the output data and one for the output-buffer control. Each cell has a capture/shift stage and an update latch. A test access port controller, which sits outside this block, drives the capture, shift and update strobes and the test-mode flag. The chain then takes serial data from the TDI side and returns serial data towards TDO.

The same path serves two purposes. It takes a non-intrusive snapshot of the pins while the core keeps control of them. It also preloads a pattern, which later drives the pads in external-test mode. A control value of 1 turns the pin's driver off. The strobes are sampled on the rising edge of the test clock.

Top module: `bscan_pin_chain`

## Requirements
- R1: The chain holds 3*NPINS cells. Pin p owns position 3p (input cell), position 3p+1 (output cell) and position 3p+2 (control cell). Position 0 drives `scan_out`, and position 3*NPINS-1 takes `scan_in`. Seen from the TDI side, each pin's cells therefore run control, output, input.
- R2: A rising clock edge with `capture_en` high loads the shift stage. The input cell takes `pad_in[p]`, the output cell takes `core_out[p]`, and the control cell takes the inverse of `core_oe[p]`.
- R3: A rising edge with `shift_en` high and `capture_en` low moves every bit one position towards `scan_out`, and `scan_in` enters at the top position. `scan_out` always shows position 0, so the first bit out is the least significant bit of the captured word.
- R4: A rising edge with `update_en` high copies the whole shift stage into the update latches. Without `update_en` the latches hold, including through capture and shift.
- R5: While `extest` is 0, `pad_out` equals `core_out`, `pad_oe` equals `core_oe` and `core_in` equals `pad_in`, whatever scan activity takes place.
- R6: While `extest` is 1, `pad_out[p]` is the output latch, `pad_oe[p]` is the inverse of the control latch (1 disables the driver) and `core_in[p]` is the input latch.
- R7: Reset (`rst_n` low) sets every control latch to 1 and every other latch and every shift-stage bit to 0. Under `extest`, every pin is then undriven.
- R8: When `capture_en` and `shift_en` are both high on one edge, capture wins.
- R9: With neither `capture_en` nor `shift_en` high, the shift stage keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_in | input | 1 | Serial data from the TDI side |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| extest | input | 1 | External-test mode: the latches drive the pads |
| scan_out | output | 1 | Serial data towards TDO |
| core_out | input | NPINS | Core output data |
| core_oe | input | NPINS | Core output enable, active high |
| core_in | output | NPINS | Input value delivered to the core |
| pad_in | input | NPINS | Value seen at each pad |
| pad_out | output | NPINS | Data to each pad driver |
| pad_oe | output | NPINS | Enable of each pad driver, active high |

## Verification
On every cycle, the assertions check the following:
- the one-position shift and serial entry;
- the capture of pin 0's three cells;
- the hold of the pad drive while no update occurs under external test;
- the loading of pin 0 on update;
- the reset-time disable of all drivers;
- the stability of the shift stage when idle.

Only the bench's scenarios show the rest:
- the full cell ordering across all pins;
- the passthrough in functional mode under every combination of core and pad values;
- capture winning a clash with shift;
- the captured pad value under external test, resolved through the tri-state pad model.

// File: rtl/bscan_pin_chain.sv
module bscan_pin_chain #(
  parameter int NPINS = 4
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             scan_in,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             extest,
  output logic             scan_out,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  output logic [NPINS-1:0] core_in,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  localparam int LEN = 3 * NPINS;

  logic [LEN-1:0] sr;
  logic [LEN-1:0] upd;
  logic [LEN-1:0] cap_val;
  logic [LEN-1:0] upd_init;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign cap_val[3*p]     = pad_in[p];
    assign cap_val[3*p+1]   = core_out[p];
    assign cap_val[3*p+2]   = ~core_oe[p];
    assign upd_init[3*p]    = 1'b0;
    assign upd_init[3*p+1]  = 1'b0;
    assign upd_init[3*p+2]  = 1'b1;
    assign pad_out[p] = extest ? upd[3*p+1]  : core_out[p];
    assign pad_oe[p]  = extest ? ~upd[3*p+2] : core_oe[p];
    assign core_in[p] = extest ? upd[3*p]    : pad_in[p];
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)          sr <= '0;
    else if (capture_en) sr <= cap_val;
    else if (shift_en)   sr <= {scan_in, sr[LEN-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)         upd <= upd_init;
    else if (update_en) upd <= sr;
  end

  assign scan_out = sr[0];
endmodule

// File: rtl/bscan_pin_chain_chk.sv
module bscan_pin_chain_chk #(
  parameter int NPINS = 4
) (
  input logic             tck,
  input logic             rst_n,
  input logic             scan_in,
  input logic             capture_en,
  input logic             shift_en,
  input logic             update_en,
  input logic             extest,
  input logic             scan_out,
  input logic [NPINS-1:0] core_out,
  input logic [NPINS-1:0] core_oe,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [3*NPINS-1:0] sr
);
  localparam int LEN = 3 * NPINS;

  a_r3_shift_step: assert property (@(posedge tck) disable iff (!rst_n)
    shift_en && !capture_en |=> scan_out == $past(sr[1]) && sr[LEN-1] == $past(scan_in));

  a_r2_capture_pin0: assert property (@(posedge tck) disable iff (!rst_n)
    capture_en |=> scan_out == $past(pad_in[0]) && sr[1] == $past(core_out[0])
                   && sr[2] == !$past(core_oe[0]));

  a_r4_drive_hold: assert property (@(posedge tck) disable iff (!rst_n)
    extest && $past(extest) && !$past(update_en) |-> $stable(pad_out) && $stable(pad_oe));

  a_r6_update_pin0: assert property (@(posedge tck) disable iff (!rst_n)
    $past(update_en) && extest |-> pad_out[0] == $past(sr[1]) && pad_oe[0] == !$past(sr[2]));

  a_r7_reset_off: assert property (@(posedge tck) disable iff (!rst_n)
    !$past(rst_n) && extest |-> pad_oe == '0);

  a_r9_idle_hold: assert property (@(posedge tck) disable iff (!rst_n)
    !capture_en && !shift_en |=> $stable(sr));
endmodule

bind bscan_pin_chain bscan_pin_chain_chk #(.NPINS(NPINS)) u_chk (
  .tck(tck), .rst_n(rst_n), .scan_in(scan_in), .capture_en(capture_en),
  .shift_en(shift_en), .update_en(update_en), .extest(extest), .scan_out(scan_out),
  .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in), .pad_out(pad_out),
  .pad_oe(pad_oe), .sr(sr)
);

// File: tb/tb_bscan_pin_chain.sv
module tb_bscan_pin_chain;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;
  localparam int LEN = 3 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_in = 1'b0, capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, extest = 1'b0;
  logic scan_out;
  logic [N-1:0] core_out = '0, core_oe = '0, core_in, pad_in, pad_out, pad_oe;
  logic [N-1:0] ext_drv = '0;
  int tests = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Pad model: the driver wins when enabled, otherwise the board level is seen
  for (genvar p = 0; p < N; p++) begin : g_pad
    assign pad_in[p] = pad_oe[p] ? pad_out[p] : ext_drv[p];
  end

  bscan_pin_chain #(.NPINS(N)) dut (
    .tck(clk), .rst_n(rst_n), .scan_in(scan_in), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .extest(extest), .scan_out(scan_out),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [LEN-1:0] cap_word(input logic [N-1:0] pin, input logic [N-1:0] dout,
                                               input logic [N-1:0] doe);
    logic [LEN-1:0] w;
    for (int p = 0; p < N; p++) begin
      w[3*p] = pin[p]; w[3*p+1] = dout[p]; w[3*p+2] = ~doe[p];
    end
    return w;
  endfunction

  function automatic logic [N-1:0] field(input logic [LEN-1:0] w, input int off);
    logic [N-1:0] f;
    for (int p = 0; p < N; p++) f[p] = w[3*p+off];
    return f;
  endfunction

  task automatic do_scan(input logic [LEN-1:0] din, input bit cap, output logic [LEN-1:0] dout);
    if (cap) begin capture_en = 1'b1; @(negedge clk); capture_en = 1'b0; end
    shift_en = 1'b1;
    for (int i = 0; i < LEN; i++) begin
      dout[i] = scan_out; scan_in = din[i]; @(negedge clk);
    end
    shift_en = 1'b0;
  endtask

  task automatic do_update();
    update_en = 1'b1; @(negedge clk); update_en = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 200000) begin
        tests++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [LEN-1:0] din, dout, dout2, expw;
    logic [N-1:0] lo, loe, lin, pexp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: reset state
    extest = 1'b1; core_oe = '1; core_out = '1; ext_drv = '1;
    @(negedge clk);
    chk(pad_oe == '0, "R7 drivers off", pad_oe, 0);
    chk(pad_out == '0, "R7 out latches", pad_out, 0);
    chk(core_in == '0, "R7 in latches", core_in, 0);
    extest = 1'b0;
    do_scan('0, 1'b0, dout);
    chk(dout == '0, "R7 shift stage", dout, 0);

    // Sweep: every core/pad combination
    for (int v = 0; v < (1 << LEN); v++) begin
      core_out = v[N-1:0]; core_oe = v[2*N-1:N]; ext_drv = v[3*N-1:2*N];
      extest = 1'b0;
      @(negedge clk);
      pexp = (core_oe & core_out) | (~core_oe & ext_drv);
      chk(pad_out == core_out && pad_oe == core_oe && core_in == pexp, "R5 passthrough",
          {pad_out, pad_oe, core_in}, {core_out, core_oe, pexp});
      din = LEN'((v * 149 + 5) % (1 << LEN));
      do_scan(din, 1'b1, dout);
      expw = cap_word(pexp, core_out, core_oe);
      chk(dout == expw, "R1 R2 R3 capture and shift order", dout, expw);
      chk(pad_out == core_out && pad_oe == core_oe, "R5 during scan", {pad_out, pad_oe},
          {core_out, core_oe});
      do_update();
      extest = 1'b1;
      @(negedge clk);
      lo = field(din, 1); loe = ~field(din, 2); lin = field(din, 0);
      chk(pad_out == lo && pad_oe == loe && core_in == lin, "R6 R4 latched drive",
          {pad_out, pad_oe, core_in}, {lo, loe, lin});
      do_scan(~din, 1'b1, dout2);
      pexp = (loe & lo) | (~loe & ext_drv);
      expw = cap_word(pexp, core_out, core_oe);
      chk(dout2 == expw, "R2 capture under extest", dout2, expw);
      chk(pad_out == lo && pad_oe == loe, "R4 hold through scan", {pad_out, pad_oe}, {lo, loe});
    end
    extest = 1'b0;

    // R8: capture beats shift
    core_out = 3'b101; core_oe = 3'b011; ext_drv = 3'b010;
    @(negedge clk);
    capture_en = 1'b1; shift_en = 1'b1; scan_in = 1'b1;
    @(negedge clk);
    capture_en = 1'b0; shift_en = 1'b0;
    pexp = (core_oe & core_out) | (~core_oe & ext_drv);
    do_scan('0, 1'b0, dout);
    expw = cap_word(pexp, core_out, core_oe);
    chk(dout == expw, "R8 capture priority", dout, expw);

    // R9: idle cycles keep the captured word
    core_out = 3'b010; core_oe = 3'b110; ext_drv = 3'b001;
    @(negedge clk);
    capture_en = 1'b1; @(negedge clk); capture_en = 1'b0;
    core_out = 3'b111; core_oe = 3'b000;
    repeat (5) @(negedge clk);
    do_scan('0, 1'b0, dout);
    expw = cap_word(3'b011, 3'b010, 3'b110);
    chk(dout == expw, "R9 idle hold", dout, expw);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule